// File: doc/BRIEF.md
# Pin-Change Wake Monitor

This block watches a parallel input port and notices when it moves away from a snapshot that software took the last time it read the port. Any difference latches a sticky change flag. While the core is asleep, a latched flag whose source is enabled raises a wake request. When the core is awake, or has just woken, the same flag raises a request to branch to the interrupt vector. That branch request also needs the global interrupt enable, so a core woken with the global enable low simply carries on with the next instruction.

The block also keeps the two reset-status bits that software inspects to learn why it is running. These are a "timeout" bit T and a "power" bit P. They are updated by watchdog clears, watchdog expiries, sleep entry and pin-change wake-ups. The pins pass through a synchroniser before any comparison. The CPU and the port-direction logic sit outside this block.

Top module: `pin_wake_monitor`

## Requirements
- R1: Each pin passes through a two-stage synchroniser. A pin change applied just after a clock edge is not visible in the change flag after two further edges, and is visible after three.
- R2: On a cycle with `port_rd` high, the reference snapshot loads the synchronised port value and not the raw pins. A pin change driven in the same cycle as the read is therefore still reported later.
- R3: The change flag is set on the edge after the synchronised port differs from the reference in any bit. It is not set when the two match.
- R4: Once set, the change flag stays set when the pins return to the reference value. Only `flag_clr` removes it.
- R5: `flag_clr` forces the flag to 0 on the next edge, even when a mismatch is present. If the mismatch persists, the flag sets again one edge later.
- R6: `vec_req` is high exactly when the individual enable, the change flag and the global enable are all high. `vec_addr` then reads 0x008 and otherwise reads 0.
- R7: Raising the individual enable while a change is already latched raises `vec_req` in the same cycle, with no clock edge needed.
- R8: `wake_req` is high exactly when the core is asleep, the individual enable is high and the flag is set. It does not depend on the global enable.
- R9: After reset the flag is 0 and the status bits read T=1, P=1.
- R10: Status updates use this priority, highest first:
  - a watchdog timeout clears T and keeps P;
  - otherwise a watchdog clear sets T=1, P=1;
  - otherwise sleep entry sets T=1, P=0;
  - otherwise an asserted wake request sets T=1, P=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | WIDTH | Raw port pins |
| port_rd | input | 1 | Software port-read strobe; loads the reference |
| flag_clr | input | 1 | Software clear of the change flag |
| chg_ie | input | 1 | Individual enable of the change interrupt |
| gie | input | 1 | Global interrupt enable |
| asleep | input | 1 | Core is in sleep state |
| wdt_clr | input | 1 | Watchdog-clear event |
| sleep_enter | input | 1 | Sleep-entry event |
| wdt_timeout | input | 1 | Watchdog expiry event |
| chg_flag | output | 1 | Latched change flag |
| wake_req | output | 1 | Wake request to the sleep controller |
| vec_req | output | 1 | Branch-to-vector request |
| vec_addr | output | ADDR_W | Vector address while `vec_req` is high, else 0 |
| stat_t | output | 1 | Reset-status timeout bit |
| stat_p | output | 1 | Reset-status power bit |

## Verification
A corrupted reference or synchroniser stage appears as a flag that rises one edge early or late, or not at all, relative to the pin change. The bench therefore samples the flag on both sides of the third edge for every pin value against several snapshots. A flag that clears itself appears within three edges, once the pins are returned to the snapshot. A wrong status priority appears on the single edge after the colliding events, where T and P are read directly.

// File: rtl/pin_wake_monitor.sv
module pin_wake_monitor #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 12,
  parameter int VECTOR      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pins,
  input  logic              port_rd,
  input  logic              flag_clr,
  input  logic              chg_ie,
  input  logic              gie,
  input  logic              asleep,
  input  logic              wdt_clr,
  input  logic              sleep_enter,
  input  logic              wdt_timeout,
  output logic              chg_flag,
  output logic              wake_req,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              stat_t,
  output logic              stat_p
);

  logic [WIDTH-1:0] sync_pipe [SYNC_STAGES];
  logic [WIDTH-1:0] sync_val;
  logic [WIDTH-1:0] snap_q;
  logic             mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_pipe[i] <= '0;
    end else begin
      sync_pipe[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_pipe[i] <= sync_pipe[i-1];
    end
  end

  assign sync_val = sync_pipe[SYNC_STAGES-1];
  assign mismatch = |(sync_val ^ snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (port_rd) snap_q <= sync_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chg_flag <= 1'b0;
    else if (flag_clr) chg_flag <= 1'b0;
    else if (mismatch) chg_flag <= 1'b1;
  end

  assign wake_req = asleep & chg_ie & chg_flag;
  assign vec_req  = chg_ie & chg_flag & gie;
  assign vec_addr = vec_req ? ADDR_W'(VECTOR) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_t <= 1'b1;
      stat_p <= 1'b1;
    end else if (wdt_timeout) begin
      stat_t <= 1'b0;
    end else if (wdt_clr) begin
      stat_t <= 1'b1;
      stat_p <= 1'b1;
    end else if (sleep_enter || wake_req) begin
      stat_t <= 1'b1;
      stat_p <= 1'b0;
    end
  end

  a_r2_snap_loads_sync: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> snap_q == $past(sync_val));
  a_r3_flag_follows_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> $past(sync_val) != $past(snap_q));
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag && !flag_clr |=> chg_flag);
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !chg_flag);
  a_r8_wake_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> !wake_req);
  a_r10_timeout_clears_t: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !stat_t && stat_p == $past(stat_p));
  a_r10_wdt_clear_sets_tp: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr && !wdt_timeout |=> stat_t && stat_p);
  a_r10_wake_sets_t_clears_p: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req && !wdt_timeout && !wdt_clr |=> stat_t && !stat_p);

endmodule

// File: tb/pin_wake_monitor_tb.sv
module pin_wake_monitor_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pins = 0;
  logic port_rd = 0, flag_clr = 0, chg_ie = 0, gie = 0, asleep = 0;
  logic wdt_clr = 0, sleep_enter = 0, wdt_timeout = 0;
  logic chg_flag, wake_req, vec_req, stat_t, stat_p;
  logic [11:0] vec_addr;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  pin_wake_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .port_rd(port_rd), .flag_clr(flag_clr),
    .chg_ie(chg_ie), .gie(gie), .asleep(asleep), .wdt_clr(wdt_clr),
    .sleep_enter(sleep_enter), .wdt_timeout(wdt_timeout), .chg_flag(chg_flag),
    .wake_req(wake_req), .vec_req(vec_req), .vec_addr(vec_addr),
    .stat_t(stat_t), .stat_p(stat_p));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture(input logic [7:0] v);
    pins = v;
    tick(2);
    port_rd = 1; flag_clr = 1;
    tick();
    port_rd = 0; flag_clr = 0;
    tick();
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] refs [4];
    refs[0] = 8'h00; refs[1] = 8'hFF; refs[2] = 8'hA5; refs[3] = 8'h3C;
    tick(2);
    check("R9 flag after reset", chg_flag, 0);
    check("R9 T after reset", stat_t, 1);
    check("R9 P after reset", stat_p, 1);
    check("R6 vec_addr idle", vec_addr, 0);
    rst_n = 1;
    tick();

    for (int r = 0; r < 4; r++) begin
      for (int v = 0; v < 256; v++) begin
        capture(refs[r]);
        pins = 8'(v);
        tick(2);
        check("R1 flag not yet after two edges", chg_flag, 0);
        tick();
        check("R3 flag vs mismatch", chg_flag, (8'(v) != refs[r]));
        if (8'(v) != refs[r]) begin
          pins = refs[r];
          tick(3);
          check("R4 flag sticky after pins return", chg_flag, 1);
        end
      end
    end

    capture(8'h00);
    pins = 8'h11; port_rd = 1;
    tick();
    port_rd = 0;
    tick(2);
    check("R2 snapshot took synced value", chg_flag, 1);
    flag_clr = 1; port_rd = 1;
    tick();
    flag_clr = 0; port_rd = 0;
    tick(2);
    check("R2 flag stays clear after read", chg_flag, 0);

    capture(8'h00);
    pins = 8'h80;
    tick(3);
    check("R3 single bit set flag", chg_flag, 1);
    flag_clr = 1;
    tick();
    flag_clr = 0;
    check("R5 clear forces 0", chg_flag, 0);
    tick();
    check("R5 persisting mismatch resets flag", chg_flag, 1);

    for (int c = 0; c < 8; c++) begin
      capture(8'h00);
      chg_ie = c[0]; gie = c[1];
      if (c[2]) begin pins = 8'h01; tick(3); end
      #1;
      check("R6 vec_req combination", vec_req, c[0] & c[1] & c[2]);
      check("R6 vec_addr combination", vec_addr, (c[0] & c[1] & c[2]) ? 12'h008 : 12'h000);
      check("R8 awake no wake", wake_req, 0);
      asleep = 1; #1;
      check("R8 asleep wake combination", wake_req, c[0] & c[2]);
      asleep = 0;
      tick();
    end

    capture(8'h00);
    chg_ie = 0; gie = 1;
    pins = 8'h02;
    tick(3);
    check("R7 no request while disabled", vec_req, 0);
    chg_ie = 1; #1;
    check("R7 pending gives immediate request", vec_req, 1);
    chg_ie = 0; gie = 0;
    tick();

    capture(8'h00);
    sleep_enter = 1; tick(); sleep_enter = 0;
    check("R10 sleep entry T", stat_t, 1);
    check("R10 sleep entry P", stat_p, 0);
    wdt_clr = 1; tick(); wdt_clr = 0;
    check("R10 wdt clear T", stat_t, 1);
    check("R10 wdt clear P", stat_p, 1);
    wdt_timeout = 1; wdt_clr = 1; tick(); wdt_timeout = 0; wdt_clr = 0;
    check("R10 timeout beats clear T", stat_t, 0);
    check("R10 timeout keeps P", stat_p, 1);
    wdt_clr = 1; sleep_enter = 1; tick(); wdt_clr = 0; sleep_enter = 0;
    check("R10 clear beats sleep P", stat_p, 1);
    wdt_timeout = 1; tick(); wdt_timeout = 0;
    check("R10 timeout T", stat_t, 0);

    asleep = 1; chg_ie = 1; gie = 0;
    pins = 8'h40;
    tick(2);
    check("R8 no wake before flag", wake_req, 0);
    tick();
    check("R8 wake without global enable", wake_req, 1);
    check("R6 no vector with global enable low", vec_req, 0);
    check("R10 status before wake edge", stat_t, 0);
    tick();
    check("R10 wake sets T", stat_t, 1);
    check("R10 wake clears P", stat_p, 0);
    asleep = 0; gie = 1; #1;
    check("R6 vector after wake with global enable", vec_req, 1);
    check("R6 vector address", vec_addr, 12'h008);
    tick();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule